// File: doc/BRIEF.md
# Banked Memory-Map Decoder

This block decodes a 16-bit CPU address into the chip selects of an 8-bit machine with a 64K address space. It has two small bank registers that widen the reach of the banked RAM window and of the ROM window. Each cycle it looks at the address and drives active-low selects for four regions: plain RAM, the I/O page, the banked RAM window and the ROM. Inside the I/O page it also drives eight active-low device selects, one for each 32-byte slot.

The two bank registers sit at the bottom of zero page. The RAM bank register is at $0000 and the ROM bank register is at $0001. The decode tree branches on the top address bit first. The lower half either hits one of the bank registers or falls through to plain RAM. The upper half is split into ROM, banked RAM, the I/O page and the remainder of plain RAM.

A write to a bank register captures the data bus on the rising clock edge. A read of a bank register returns its value on a separate read-data output, together with a valid flag. The bank values are driven continuously on two extended-address outputs, which feed the upper address lines of the banked RAM and the ROM.

Top module: `mmap_decoder`

## Requirements
- R1: All selects are active low. Plain RAM (`ram_lo_cs_n`) covers $0000–$9EFF except $0000 and $0001. The I/O page (`io_cs_n`) covers $9F00–$9FFF. Banked RAM (`ram_hi_cs_n`) covers $A000–$BFFF. ROM (`rom_cs_n`) covers $C000–$FFFF.
- R2: Out of reset, exactly one of the four region selects is low for every address other than $0000 and $0001. For those two addresses all four region selects are high.
- R3: Inside the I/O page, `io_dev_cs_n[k]` is low only for k = address bits [7:5], so each device slot spans 32 bytes. Outside the I/O page all eight device selects are high.
- R4: If `bus_we`=1 at a rising clock edge with address $0000, `bus_wdata` is loaded into the RAM bank register. With address $0001 it is loaded into the ROM bank register instead. The new value appears on the outputs in the cycle after that edge.
- R5: A write to any other address leaves both bank registers unchanged. A read, whatever its address, also leaves both bank registers unchanged.
- R6: When `bus_we`=0 and the address is $0000 or $0001, `breg_rvalid` is 1 and `breg_rdata` shows the RAM bank (address $0000) or the ROM bank (address $0001). In every other case `breg_rvalid` is 0 and `breg_rdata` is 0.
- R7: `ram_hi_bank` always drives the RAM bank register and `rom_bank` always drives the ROM bank register. Neither output is ever undriven.
- R8: `rst_n` is a synchronous, active-low reset. It clears both bank registers and overrides a write in the same cycle. While `rst_n` is low, every select is high and `breg_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_we | input | 1 | Write strobe, 1 = write cycle |
| bus_wdata | input | 8 | CPU write data |
| ram_lo_cs_n | output | 1 | Plain RAM select, active low |
| io_cs_n | output | 1 | I/O page select, active low |
| ram_hi_cs_n | output | 1 | Banked RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| io_dev_cs_n | output | 8 | Per-slot I/O device selects, active low |
| ram_hi_bank | output | 8 | Extended address bits for banked RAM |
| rom_bank | output | 8 | Extended address bits for ROM |
| breg_rdata | output | 8 | Bank register read data |
| breg_rvalid | output | 1 | Bank register read in progress |

## Verification
Two events can fall on the same clock edge: a write to a bank register and a synchronous reset. The bench provokes this by holding `rst_n` low while it drives a write of a non-zero value to $0000. It then expects the RAM bank to read zero on the following cycle, which shows that reset took priority. A behavioural model tracks both bank values and the expected region for every address across a full 65536-address sweep, followed by a pseudo-random mix of reads and writes. Every output of the block is compared against the model on every clock.

// File: rtl/mmap_pkg.sv
// Package: shared constants for the memory-map decoder.
// Assumes a byte-wide data bus and a region layout keyed on the upper address bits.
package mmap_pkg;

    // Number of bank registers (RAM bank, ROM bank).
    localparam int unsigned BREG_COUNT = 2;

    // Index of each bank register, equal to address bit 0 of its location.
    localparam int unsigned BREG_RAM = 0;
    localparam int unsigned BREG_ROM = 1;

    // Region hit vector, one bit per region, active high.
    typedef struct packed {
        logic ram_lo;
        logic io;
        logic ram_hi;
        logic rom;
        logic breg;
    } region_hit_t;

endpackage

// File: rtl/mmap_region_decode.sv
// Module: mmap_region_decode
// Turns the CPU address into region hits. The decode branches on the top
// address bit first. The lower half decides between the bank registers and
// plain RAM. The upper half decides between ROM, the banked RAM window, the
// I/O page and plain RAM. Plain RAM is whatever nothing else claims.
// Assumes: ROM is the top quarter of the space, banked RAM the eighth below
// it, and the I/O page tag lies inside the upper half. All hits are forced
// low while reset is active.
module mmap_region_decode
    import mmap_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned IO_TAG_W = 8,
    parameter logic [IO_TAG_W-1:0] IO_TAG = 8'h9F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output region_hit_t       hit
);

    localparam int unsigned MSB = ADDR_W - 1;

    region_hit_t raw;

    // Two-way split on the top bit, then region choice within each half.
    always_comb begin
        raw = '0;
        if (addr[MSB]) begin
            if (addr[MSB-1]) begin
                raw.rom = 1'b1;
            end else if (addr[MSB-2]) begin
                raw.ram_hi = 1'b1;
            end else if (addr[MSB -: IO_TAG_W] == IO_TAG) begin
                raw.io = 1'b1;
            end else begin
                raw.ram_lo = 1'b1;
            end
        end else begin
            if (addr[MSB-1:1] == '0) begin
                raw.breg = 1'b1;
            end else begin
                raw.ram_lo = 1'b1;
            end
        end
    end

    // Suppress every hit while reset is held.
    always_comb begin
        hit = rst_n ? raw : '0;
    end

    // R2: at most one region hit in any cycle out of reset.
    p_region_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) == 1)
        else $error("region hit vector not one-hot");

    // R2: the two zero-page register addresses claim no memory region.
    p_breg_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[MSB:1] == '0) |-> (hit.breg && !hit.ram_lo && !hit.io && !hit.ram_hi && !hit.rom))
        else $error("bank register address leaked to a memory region");

endmodule

// File: rtl/mmap_io_decode.sv
// Module: mmap_io_decode
// Turns the device index field of an I/O-page access into one active-low
// select per device slot.
// Assumes: io_hit is already qualified by reset and by the page compare.
module mmap_io_decode #(
    parameter int unsigned DEV_COUNT = 8,
    parameter int unsigned IDX_W     = $clog2(DEV_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_hit,
    input  logic [IDX_W-1:0]     dev_idx,
    output logic [DEV_COUNT-1:0] dev_cs_n
);

    // One comparator per device slot.
    for (genvar k = 0; k < DEV_COUNT; k++) begin : g_slot
        always_comb begin
            dev_cs_n[k] = !(io_hit && (dev_idx == IDX_W'(k)));
        end
    end

    // R3: exactly one device select is low during an I/O-page access.
    p_dev_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> ($countones(~dev_cs_n) == 1))
        else $error("device selects not one-hot in I/O page");

    // R3: no device select is low outside the I/O page.
    p_dev_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> (&dev_cs_n))
        else $error("device select low outside I/O page");

endmodule

// File: rtl/mmap_bank_regs.sv
// Module: mmap_bank_regs
// Holds the bank registers. On a rising edge, a write cycle that hits the
// register block loads the data bus into the register picked by reg_idx.
// The register contents are driven continuously, never tri-stated.
// Assumes: reg_hit already carries the full zero-page address compare.
module mmap_bank_regs
    import mmap_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NREG   = BREG_COUNT,
    parameter int unsigned IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_hit,
    input  logic [IDX_W-1:0]       reg_idx,
    input  logic                   we,
    input  logic [DATA_W-1:0]      wdata,
    output logic [NREG*DATA_W-1:0] regs_flat
);

    logic [DATA_W-1:0] q [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // Capture the data bus on a write aimed at this register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[k] <= '0;
            end else if (we && reg_hit && (reg_idx == IDX_W'(k))) begin
                q[k] <= wdata;
            end
        end

        // Expose the register on its slice of the flat output.
        always_comb begin
            regs_flat[k*DATA_W +: DATA_W] = q[k];
        end
    end

    // R4: a write that hits the block lands in the addressed register.
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && reg_hit) |=> (regs_flat[$past(reg_idx)*DATA_W +: DATA_W] == $past(wdata)))
        else $error("bank register did not capture write data");

    // R5: without a write hit, no register changes.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && reg_hit) |=> $stable(regs_flat))
        else $error("bank register changed without a write hit");

endmodule

// File: rtl/mmap_decoder.sv
// Module: mmap_decoder (top)
// Address decode and banking unit for an 8-bit CPU with a 64K address space.
// Combines the region decoder, the I/O device decoder and the bank
// registers. It drives the active-low chip selects, the extended bank
// address bits and the bank register read path.
// Assumes: one bus access per clock; the address, strobe and data are
// stable by the rising edge.
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned IO_TAG_W  = 8,
    parameter logic [IO_TAG_W-1:0] IO_TAG = 8'h9F,
    parameter int unsigned DEV_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 ram_lo_cs_n,
    output logic                 io_cs_n,
    output logic                 ram_hi_cs_n,
    output logic                 rom_cs_n,
    output logic [DEV_COUNT-1:0] io_dev_cs_n,
    output logic [DATA_W-1:0]    ram_hi_bank,
    output logic [DATA_W-1:0]    rom_bank,
    output logic [DATA_W-1:0]    breg_rdata,
    output logic                 breg_rvalid
);

    localparam int unsigned PAGE_W  = ADDR_W - IO_TAG_W;
    localparam int unsigned DEV_IDX = $clog2(DEV_COUNT);
    localparam int unsigned BREG_IW = $clog2(BREG_COUNT);

    region_hit_t                    hit;
    logic [BREG_COUNT*DATA_W-1:0]   regs_flat;
    logic [BREG_IW-1:0]             breg_idx;

    mmap_region_decode #(
        .ADDR_W   (ADDR_W),
        .IO_TAG_W (IO_TAG_W),
        .IO_TAG   (IO_TAG)
    ) i_region (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .hit   (hit)
    );

    mmap_io_decode #(
        .DEV_COUNT (DEV_COUNT),
        .IDX_W     (DEV_IDX)
    ) i_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_hit   (hit.io),
        .dev_idx  (bus_addr[PAGE_W-1 -: DEV_IDX]),
        .dev_cs_n (io_dev_cs_n)
    );

    // Pick the bank register from the low address bits.
    always_comb begin
        breg_idx = bus_addr[BREG_IW-1:0];
    end

    mmap_bank_regs #(
        .DATA_W (DATA_W),
        .NREG   (BREG_COUNT),
        .IDX_W  (BREG_IW)
    ) i_bregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_hit   (hit.breg),
        .reg_idx   (breg_idx),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .regs_flat (regs_flat)
    );

    // Drive the active-low region selects.
    always_comb begin
        ram_lo_cs_n = !hit.ram_lo;
        io_cs_n     = !hit.io;
        ram_hi_cs_n = !hit.ram_hi;
        rom_cs_n    = !hit.rom;
    end

    // Present the bank values as extended address bits.
    always_comb begin
        ram_hi_bank = regs_flat[BREG_RAM*DATA_W +: DATA_W];
        rom_bank    = regs_flat[BREG_ROM*DATA_W +: DATA_W];
    end

    // Return the addressed bank register on a read cycle.
    always_comb begin
        breg_rvalid = hit.breg && !bus_we;
        breg_rdata  = breg_rvalid ? regs_flat[breg_idx*DATA_W +: DATA_W] : '0;
    end

    // R6: a bank register read never selects plain RAM.
    p_read_no_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
        breg_rvalid |-> ram_lo_cs_n)
        else $error("bank register read also selected RAM");

    // R8: a cycle held in reset leaves both bank values cleared.
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (ram_hi_bank == '0 && rom_bank == '0))
        else $error("reset did not clear bank registers");

endmodule

// File: tb/test_mmap_decoder.sv
// Bench: behavioural reference model of the decoder, compared on every clock.
module test_mmap_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        ram_lo_cs_n, io_cs_n, ram_hi_cs_n, rom_cs_n;
    logic [7:0]  io_dev_cs_n, ram_hi_bank, rom_bank, breg_rdata;
    logic        breg_rvalid;

    int total = 0;
    int bad   = 0;
    int m_ram = 0;
    int m_rom = 0;
    bit done  = 1'b0;

    always #10 clk = !clk;

    mmap_decoder i_mmap_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .ram_lo_cs_n (ram_lo_cs_n),
        .io_cs_n     (io_cs_n),
        .ram_hi_cs_n (ram_hi_cs_n),
        .rom_cs_n    (rom_cs_n),
        .io_dev_cs_n (io_dev_cs_n),
        .ram_hi_bank (ram_hi_bank),
        .rom_bank    (rom_bank),
        .breg_rdata  (breg_rdata),
        .breg_rvalid (breg_rvalid)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (addr=%04h we=%0d)", req, act, exp, bus_addr, bus_we);
        end
    endtask

    // Expected selects {ram_lo, io, ram_hi, rom}, active low, from the map.
    function automatic logic [3:0] exp_region(input int a, input bit r);
        if (!r || a <= 1)    return 4'b1111;
        if (a < 'h9F00)      return 4'b0111;
        if (a < 'hA000)      return 4'b1011;
        if (a < 'hC000)      return 4'b1101;
        return 4'b1110;
    endfunction

    // Drive one bus cycle, check outputs mid-cycle, then advance the model.
    task automatic step(input bit r, input int a, input bit we, input int d, input string tag);
        logic [3:0] er;
        logic [7:0] edev;
        bit         erv;
        int         erd;
        @(negedge clk);
        rst_n = r; bus_addr = 16'(a); bus_we = we; bus_wdata = 8'(d);
        #5;
        er = exp_region(a, r);
        chk("R1", {ram_lo_cs_n, io_cs_n, ram_hi_cs_n, rom_cs_n}, er);
        if (r) chk("R2", $countones(~{ram_lo_cs_n, io_cs_n, ram_hi_cs_n, rom_cs_n}), (a <= 1) ? 0 : 1);
        edev = 8'hFF;
        if (!er[2]) edev[(a >> 5) & 7] = 1'b0;
        chk("R3", io_dev_cs_n, edev);
        erv = r && !we && a <= 1;
        erd = erv ? ((a == 0) ? m_ram : m_rom) : 0;
        chk("R6", breg_rvalid, erv);
        chk("R6", breg_rdata, erd);
        chk(tag, ram_hi_bank, m_ram);
        chk(tag, rom_bank, m_rom);
        @(posedge clk);
        if (!r) begin
            m_ram = 0; m_rom = 0;
        end else if (we && a == 0) begin
            m_ram = d;
        end else if (we && a == 1) begin
            m_rom = d;
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(20 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lfsr = 'hACE1;
        // R8: reset state, selects idle.
        for (int i = 0; i < 3; i++) step(0, 'hA000 + i, 0, 0, "R8");
        // R4: load both bank registers.
        step(1, 0, 1, 'h3C, "R7");
        step(1, 1, 1, 'hA5, "R4");
        step(1, 0, 0, 0, "R4");
        step(1, 1, 0, 0, "R6");
        step(1, 'hA123, 0, 0, "R7");
        step(1, 'hD000, 0, 0, "R7");
        // R5: writes elsewhere leave the banks alone.
        step(1, 2, 1, 'hFF, "R5");
        step(1, 'h8000, 1, 'hFF, "R5");
        step(1, 'h8001, 1, 'hFF, "R5");
        step(1, 'h0100, 1, 'hFF, "R5");
        step(1, 'h9F00, 1, 'hFF, "R5");
        step(1, 0, 0, 0, "R5");
        // R8: reset collides with a write to $0000; reset must win.
        step(0, 0, 1, 'h55, "R8");
        step(1, 0, 0, 0, "R8");
        step(1, 0, 1, 'h81, "R4");
        step(1, 1, 1, 'h7E, "R4");
        // R1/R2/R3: full address sweep with reads.
        for (int a = 0; a < 65536; a++) step(1, a, 0, 0, "R7");
        // R4/R5/R7: pseudo-random mix, biased toward the register addresses.
        for (int i = 0; i < 3000; i++) begin
            int a;
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
            a = ((lfsr & 3) == 0) ? ((lfsr >> 2) & 1) : lfsr;
            step(1, a, (lfsr >> 4) & 1, (lfsr >> 7) & 'hFF, "R7");
        end
        step(1, 0, 0, 0, "R6");
        step(1, 1, 0, 0, "R6");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule